// File: doc/BRIEF.md
# Packed-Lane Compare and Predicate Setter

This block takes two 32-bit source words and pulls one sub-word operand out of each, either a single byte or one halfword. The second operand may instead come from a 16-bit immediate. The two operands are compared under a selectable integer condition. The one-bit result is then merged with a predicate bit, read from the block's own 8-entry predicate file, through a selectable boolean operator.

One operation writes two destination predicates. The primary destination receives the comparison merged with the input predicate. The secondary destination receives the inverted comparison, merged with the same predicate through the same operator. Entry 7 of the file is a constant that always reads 1. A secondary destination of 7 means "no second write". A primary destination of 7 is an illegal request and raises an error.

Top module: `vcp_pred_cmp`

## Requirements
- R1: After a clock edge with `rst_n` low, `pred_o` equals 8'h80 (entries 0 to 6 clear, entry 7 set) and `err_o` is 0.
- R2: Lane extraction for operand A, and for operand B when `b_from_reg_i`=1. In byte mode (`*_byte_i`=1), byte `sel` (bits 8*sel+7 down to 8*sel) is taken. In halfword mode, `sel[0]`=0 takes bits 15:0, `sel[0]`=1 takes bits 31:16, and `sel[1]` is ignored. The lane is sign-extended when that operand's signed flag is 1 and zero-extended otherwise.
- R3: When `b_from_reg_i`=0, operand B is `imm_b_i`, sign-extended if `b_signed_i`=1 and zero-extended otherwise.
- R4: The comparison is signed when either `a_signed_i` or `b_signed_i` is 1, and unsigned otherwise.
- R5: `cond_i` codes: 0 false, 1 A<B, 2 A==B, 3 A<=B, 4 A>B, 5 A!=B, 6 A>=B, 7 true.
- R6: `comb_i` codes: 0 AND, 1 OR, 2 XOR. Code 3 is reserved.
- R7: The primary entry `dst_p_i` receives (compare `comb` P), where P is the entry at `pin_idx_i` before the write. Reading index 7 gives 1.
- R8: The secondary entry `dst_q_i` receives (not compare `comb` P), and is left unchanged when `dst_q_i`=7.
- R9: Writes take effect on the edge where `valid_i` is 1, and both destinations update on that same edge. With `valid_i`=0, and for entries not addressed, the file holds its value.
- R10: When `dst_p_i` equals `dst_q_i` (and is not 7), the primary result is stored.
- R11: A valid request with `dst_p_i`=7 or `comb_i`=3 writes no entry and drives `err_o` high for exactly the cycle after that edge.
- R12: Entry 7 reads as 1 at all times, both on `pred_o[7]` and as an input predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| src_a_i | input | 32 | Source word for operand A |
| src_b_i | input | 32 | Source word for operand B |
| imm_b_i | input | 16 | Immediate for operand B |
| b_from_reg_i | input | 1 | 1: B from `src_b_i`, 0: B from immediate |
| a_byte_i | input | 1 | A lane is a byte (1) or a halfword (0) |
| a_sel_i | input | 2 | A byte index or halfword select |
| a_signed_i | input | 1 | A is signed |
| b_byte_i | input | 1 | B lane is a byte (1) or a halfword (0) |
| b_sel_i | input | 2 | B byte index or halfword select |
| b_signed_i | input | 1 | B is signed |
| cond_i | input | 3 | Comparison condition |
| comb_i | input | 2 | Boolean combiner |
| pin_idx_i | input | 3 | Input predicate index |
| dst_p_i | input | 3 | Primary destination index |
| dst_q_i | input | 3 | Secondary destination index |
| pred_o | output | 8 | Predicate file contents |
| err_o | output | 1 | Illegal request flag |

## Verification
The two writes of one request land on the same edge. They can collide on one entry, and the input predicate can alias either destination. The bench provokes this by driving equal primary and secondary indices, and by reading a predicate in the same request that overwrites it. It judges the result against a bench-side model of the file: the primary value must win a collision, and the input predicate must be the value held before the edge. A long seeded sweep mixes these collisions with ordinary requests and error requests.

// File: rtl/vcp_pkg.sv
// vcp_pkg: shared sizes and code types for the packed-lane compare unit.
// Assumes 32-bit sources, 16-bit immediates and an 8-entry predicate file.
package vcp_pkg;
    parameter int DATA_W = 32;
    parameter int IMM_W  = 16;
    parameter int PRED_N = 8;
    localparam int PIDX_W   = $clog2(PRED_N);
    localparam int SEL_W    = $clog2(DATA_W / 8);
    localparam int TRUE_IDX = PRED_N - 1;

    typedef enum logic [2:0] {
        CMP_F  = 3'd0,
        CMP_LT = 3'd1,
        CMP_EQ = 3'd2,
        CMP_LE = 3'd3,
        CMP_GT = 3'd4,
        CMP_NE = 3'd5,
        CMP_GE = 3'd6,
        CMP_T  = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        CMB_AND  = 2'd0,
        CMB_OR   = 2'd1,
        CMB_XOR  = 2'd2,
        CMB_RSVD = 2'd3
    } comb_e;
endpackage

// File: rtl/vcp_lane_extract.sv
// vcp_lane_extract: selects a byte or halfword lane from a word and widens it.
// Assumes DATA_W is a multiple of 32; halfword mode uses sel[0] only.
module vcp_lane_extract #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 2
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              byte_mode_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] lane_o
);
    localparam int NBYTE = DATA_W / 8;

    logic [7:0]  bytes_w [NBYTE];
    logic [15:0] lo_half, hi_half, half_w;
    logic [7:0]  byte_w;

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        assign bytes_w[i] = word_i[8*i +: 8];
    end

    assign lo_half = word_i[15:0];
    assign hi_half = word_i[31:16];

    // Pick the lane and extend it by the operand's sign flag.
    always_comb begin
        byte_w = bytes_w[sel_i];
        half_w = sel_i[0] ? hi_half : lo_half;
        if (byte_mode_i)
            lane_o = {{(DATA_W-8){signed_i & byte_w[7]}}, byte_w};
        else
            lane_o = {{(DATA_W-16){signed_i & half_w[15]}}, half_w};
    end
endmodule

// File: rtl/vcp_compare.sv
// vcp_compare: evaluates one integer condition on two widened operands.
// Assumes both operands are already extended to DATA_W.
module vcp_compare
    import vcp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              signed_i,
    input  cond_e             cond_i,
    output logic              hit_o
);
    logic lt, eq;

    // Derive less-than under the selected signedness, and equality.
    always_comb begin
        lt = signed_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
        eq = (a_i == b_i);
    end

    // Map the condition code to a single result bit.
    always_comb begin
        unique case (cond_i)
            CMP_F:   hit_o = 1'b0;
            CMP_LT:  hit_o = lt;
            CMP_EQ:  hit_o = eq;
            CMP_LE:  hit_o = lt | eq;
            CMP_GT:  hit_o = ~(lt | eq);
            CMP_NE:  hit_o = ~eq;
            CMP_GE:  hit_o = ~lt;
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/vcp_pred_file.sv
// vcp_pred_file: predicate registers with two write ports and one read port.
// Assumes the top entry is a constant 1; port P wins when both ports hit an entry.
module vcp_pred_file #(
    parameter int PRED_N = 8,
    parameter int PIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_p_i,
    input  logic [PIDX_W-1:0] idx_p_i,
    input  logic              d_p_i,
    input  logic              we_q_i,
    input  logic [PIDX_W-1:0] idx_q_i,
    input  logic              d_q_i,
    input  logic [PIDX_W-1:0] rd_idx_i,
    output logic              rd_o,
    output logic [PRED_N-1:0] file_o
);
    for (genvar i = 0; i < PRED_N - 1; i++) begin : g_ent
        logic bit_q;
        // Hold one predicate; port P takes priority over port Q.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (we_p_i && idx_p_i == PIDX_W'(i))
                bit_q <= d_p_i;
            else if (we_q_i && idx_q_i == PIDX_W'(i))
                bit_q <= d_q_i;
        end
        assign file_o[i] = bit_q;
    end

    assign file_o[PRED_N-1] = 1'b1;
    assign rd_o = file_o[rd_idx_i];
endmodule

// File: rtl/vcp_pred_cmp.sv
// vcp_pred_cmp: compares two packed lanes, merges with a predicate and writes
// a true/inverted pair into the predicate file. Assumes one request per cycle.
module vcp_pred_cmp
    import vcp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [DATA_W-1:0]   src_a_i,
    input  logic [DATA_W-1:0]   src_b_i,
    input  logic [IMM_W-1:0]    imm_b_i,
    input  logic                b_from_reg_i,
    input  logic                a_byte_i,
    input  logic [SEL_W-1:0]    a_sel_i,
    input  logic                a_signed_i,
    input  logic                b_byte_i,
    input  logic [SEL_W-1:0]    b_sel_i,
    input  logic                b_signed_i,
    input  logic [2:0]          cond_i,
    input  logic [1:0]          comb_i,
    input  logic [PIDX_W-1:0]   pin_idx_i,
    input  logic [PIDX_W-1:0]   dst_p_i,
    input  logic [PIDX_W-1:0]   dst_q_i,
    output logic [PRED_N-1:0]   pred_o,
    output logic                err_o
);
    logic [DATA_W-1:0] lane_a, lane_b, opnd_b;
    logic              hit, pin_val, res_p, res_q, bad, we_p, we_q, err_q;

    vcp_lane_extract #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_lane_a (
        .word_i(src_a_i), .byte_mode_i(a_byte_i), .sel_i(a_sel_i),
        .signed_i(a_signed_i), .lane_o(lane_a)
    );

    vcp_lane_extract #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_lane_b (
        .word_i(src_b_i), .byte_mode_i(b_byte_i), .sel_i(b_sel_i),
        .signed_i(b_signed_i), .lane_o(lane_b)
    );

    // Choose operand B from the register lane or the extended immediate.
    always_comb begin
        if (b_from_reg_i)
            opnd_b = lane_b;
        else
            opnd_b = {{(DATA_W-IMM_W){b_signed_i & imm_b_i[IMM_W-1]}}, imm_b_i};
    end

    vcp_compare #(.DATA_W(DATA_W)) u_cmp (
        .a_i(lane_a), .b_i(opnd_b), .signed_i(a_signed_i | b_signed_i),
        .cond_i(cond_e'(cond_i)), .hit_o(hit)
    );

    // Merge the true and inverted comparison with the input predicate.
    always_comb begin
        unique case (comb_e'(comb_i))
            CMB_AND: begin res_p = hit & pin_val;  res_q = ~hit & pin_val;  end
            CMB_OR:  begin res_p = hit | pin_val;  res_q = ~hit | pin_val;  end
            CMB_XOR: begin res_p = hit ^ pin_val;  res_q = ~hit ^ pin_val;  end
            default: begin res_p = 1'b0;           res_q = 1'b0;            end
        endcase
    end

    // Qualify the write enables; illegal requests write nothing.
    always_comb begin
        bad  = (dst_p_i == PIDX_W'(TRUE_IDX)) || (comb_e'(comb_i) == CMB_RSVD);
        we_p = valid_i && !bad;
        we_q = valid_i && !bad && (dst_q_i != PIDX_W'(TRUE_IDX));
    end

    vcp_pred_file #(.PRED_N(PRED_N), .PIDX_W(PIDX_W)) u_file (
        .clk(clk), .rst_n(rst_n),
        .we_p_i(we_p), .idx_p_i(dst_p_i), .d_p_i(res_p),
        .we_q_i(we_q), .idx_q_i(dst_q_i), .d_q_i(res_q),
        .rd_idx_i(pin_idx_i), .rd_o(pin_val), .file_o(pred_o)
    );

    // Register the one-cycle error flag for an illegal request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= valid_i && bad;
    end

    assign err_o = err_q;
endmodule

// File: rtl/vcp_pred_cmp_chk.sv
// vcp_pred_cmp_chk: temporal checks on the predicate setter's ports.
// Assumes an 8-entry file whose top entry is the constant-true slot.
module vcp_pred_cmp_chk #(
    parameter int PRED_N = 8,
    parameter int PIDX_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [1:0]        comb_i,
    input logic [PIDX_W-1:0] dst_p_i,
    input logic [PIDX_W-1:0] dst_q_i,
    input logic [PRED_N-1:0] pred_o,
    input logic              err_o
);
    logic              req_bad;
    logic [PRED_N-1:0] touch;

    assign req_bad = (dst_p_i == PIDX_W'(PRED_N-1)) || (comb_i == 2'd3);
    assign touch   = (PRED_N'(1) << dst_p_i) | (PRED_N'(1) << dst_q_i);

    // R12: the constant slot always reads one.
    p_const_true_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pred_o[PRED_N-1]);

    // R9: no request leaves the file unchanged.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pred_o));

    // R9: only addressed entries may change.
    p_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> ((pred_o ^ $past(pred_o)) & ~$past(touch)) == '0);

    // R11: an illegal request flags and writes nothing.
    p_err_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && req_bad) |=> (err_o && $stable(pred_o)));

    // R11: the flag stays low without an illegal request.
    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && req_bad) |=> !err_o);

    // R8: with XOR the two destinations always hold opposite values.
    p_xor_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !req_bad && comb_i == 2'd2 && dst_q_i != dst_p_i
         && dst_q_i != PIDX_W'(PRED_N-1))
        |=> pred_o[$past(dst_p_i)] != pred_o[$past(dst_q_i)]);
endmodule

bind vcp_pred_cmp vcp_pred_cmp_chk #(.PRED_N(vcp_pkg::PRED_N), .PIDX_W(vcp_pkg::PIDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .comb_i(comb_i),
    .dst_p_i(dst_p_i), .dst_q_i(dst_q_i), .pred_o(pred_o), .err_o(err_o)
);

// File: tb/vcp_pred_cmp_bench.sv
// vcp_pred_cmp_bench: directed cases plus a seeded sweep against a bench model.
module vcp_pred_cmp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] src_a_i = '0, src_b_i = '0;
    logic [15:0] imm_b_i = '0;
    logic        b_from_reg_i = 1'b0, a_byte_i = 1'b0, a_signed_i = 1'b0;
    logic        b_byte_i = 1'b0, b_signed_i = 1'b0;
    logic [1:0]  a_sel_i = '0, b_sel_i = '0, comb_i = '0;
    logic [2:0]  cond_i = '0, pin_idx_i = '0, dst_p_i = '0, dst_q_i = '0;
    logic [7:0]  pred_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit [7:0] model = 8'h80;

    always #2 clk = ~clk;

    vcp_pred_cmp u_vcp_pred_cmp (.*);

    function automatic longint lane(bit [31:0] w, bit bm, bit [1:0] sel, bit sg);
        longint v;
        if (bm) begin
            v = longint'((w >> (8 * sel)) & 32'hFF);
            if (sg && v >= 128) v -= 256;
        end else begin
            v = sel[0] ? longint'(w >> 16) : longint'(w & 32'hFFFF);
            if (sg && v >= 32768) v -= 65536;
        end
        return v;
    endfunction

    function automatic bit cmp(longint a, longint b, bit [2:0] c);
        case (c)
            3'd0: return 1'b0;
            3'd1: return a < b;
            3'd2: return a == b;
            3'd3: return a <= b;
            3'd4: return a > b;
            3'd5: return a != b;
            3'd6: return a >= b;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit merge(bit x, bit p, bit [1:0] m);
        case (m)
            2'd0: return x & p;
            2'd1: return x | p;
            default: return x ^ p;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request: drive at a falling edge, check at the next falling edge.
    task automatic op(string req, bit [31:0] a, bit [31:0] b, bit [15:0] imm, bit breg,
                      bit abm, bit [1:0] asel, bit asg, bit bbm, bit [1:0] bsel, bit bsg,
                      bit [2:0] c, bit [1:0] m, bit [2:0] pin, bit [2:0] p, bit [2:0] q);
        longint va, vb;
        bit x, pv, bad;
        va = lane(a, abm, asel, asg);
        if (breg) vb = lane(b, bbm, bsel, bsg);
        else begin
            vb = longint'(imm);
            if (bsg && vb >= 32768) vb -= 65536;
        end
        x   = cmp(va, vb, c);
        pv  = model[pin];
        bad = (p == 3'd7) || (m == 2'd3);
        src_a_i = a; src_b_i = b; imm_b_i = imm; b_from_reg_i = breg;
        a_byte_i = abm; a_sel_i = asel; a_signed_i = asg;
        b_byte_i = bbm; b_sel_i = bsel; b_signed_i = bsg;
        cond_i = c; comb_i = m; pin_idx_i = pin; dst_p_i = p; dst_q_i = q;
        valid_i = 1'b1;
        if (!bad) begin
            if (q != 3'd7) model[q] = merge(!x, pv, m);
            model[p] = merge(x, pv, m);
        end
        @(negedge clk);
        valid_i = 1'b0;
        check(req, {24'b0, pred_o}, {24'b0, model});
        check(req, {31'b0, err_o}, {31'b0, bad});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 reset", {24'b0, pred_o}, 32'h80);
        check("R1 reset err", {31'b0, err_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: byte 2 unsigned equals 0x80; then signed byte is below +128.
        op("R2 byte eq", 32'h0080_0000, 0, 16'h0080, 0, 1, 2'd2, 0, 0, 0, 0, 3'd2, 2'd0, 3'd7, 3'd0, 3'd1);
        op("R2 signed byte", 32'h0080_0000, 0, 16'h0080, 0, 1, 2'd2, 1, 0, 0, 0, 3'd1, 2'd0, 3'd7, 3'd2, 3'd3);
        op("R2 high half", 32'h1234_5678, 32'h0000_1234, 0, 1, 0, 2'd1, 0, 0, 2'd2, 0, 3'd2, 2'd0, 3'd7, 3'd4, 3'd5);
        // R3: immediate 0xFFFF is -1 when signed, 65535 otherwise.
        op("R3 imm signed", 32'h0000_0000, 0, 16'hFFFF, 0, 0, 2'd0, 0, 0, 0, 1, 3'd4, 2'd0, 3'd7, 3'd0, 3'd7);
        op("R3 imm unsigned", 32'h0000_0000, 0, 16'hFFFF, 0, 0, 2'd0, 0, 0, 0, 0, 3'd4, 2'd0, 3'd7, 3'd1, 3'd7);
        // R4: signed A lane -1 against unsigned B lane 1.
        op("R4 mixed sign", 32'h0000_FFFF, 32'h0000_0001, 0, 1, 0, 2'd0, 1, 0, 2'd0, 0, 3'd1, 2'd0, 3'd7, 3'd2, 3'd7);
        // R5: every condition code on A=5, B=9.
        for (int c = 0; c < 8; c++)
            op("R5 cond", 32'h5, 0, 16'h9, 0, 0, 2'd0, 0, 0, 0, 0, 3'(c), 2'd0, 3'd7, 3'd3, 3'd4);
        // R6: each combiner against both input predicate values.
        for (int m = 0; m < 3; m++)
            for (int pin = 3; pin < 5; pin++)
                op("R6 comb", 32'h1, 0, 16'h1, 0, 0, 2'd0, 0, 0, 0, 0, 3'd2, 2'(m), 3'(pin), 3'd5, 3'd6);
        // R7: input predicate aliases the primary destination (old value read).
        op("R7 alias", 32'h1, 0, 16'h1, 0, 0, 2'd0, 0, 0, 0, 0, 3'd2, 2'd2, 3'd5, 3'd5, 3'd7);
        // R8: secondary index 7 leaves the file alone beyond the primary.
        op("R8 q skip", 32'h1, 0, 16'h2, 0, 0, 2'd0, 0, 0, 0, 0, 3'd1, 2'd1, 3'd7, 3'd6, 3'd7);
        // R9: idle cycle with live-looking inputs holds the file.
        dst_p_i = 3'd0; dst_q_i = 3'd1; cond_i = 3'd7; comb_i = 2'd1;
        @(negedge clk);
        check("R9 idle hold", {24'b0, pred_o}, {24'b0, model});
        // R10: collision, primary result kept.
        op("R10 collide", 32'h1, 0, 16'h1, 0, 0, 2'd0, 0, 0, 0, 0, 3'd2, 2'd0, 3'd7, 3'd2, 3'd2);
        op("R10 collide2", 32'h1, 0, 16'h1, 0, 0, 2'd0, 0, 0, 0, 0, 3'd5, 2'd0, 3'd7, 3'd2, 3'd2);
        // R11: primary 7, and reserved combiner.
        op("R11 p7", 32'h1, 0, 16'h1, 0, 0, 2'd0, 0, 0, 0, 0, 3'd2, 2'd0, 3'd7, 3'd7, 3'd0);
        op("R11 rsvd comb", 32'h1, 0, 16'h1, 0, 0, 2'd0, 0, 0, 0, 0, 3'd2, 2'd3, 3'd7, 3'd0, 3'd1);
        @(negedge clk);
        check("R11 err one cycle", {31'b0, err_o}, 32'h0);
        // R12: constant slot read as input with AND keeps comparison value.
        op("R12 const read", 32'h3, 0, 16'h3, 0, 0, 2'd0, 0, 0, 0, 0, 3'd2, 2'd0, 3'd7, 3'd1, 3'd0);

        // Seeded sweep over every field.
        for (int k = 0; k < 4000; k++)
            op("sweep", $urandom, $urandom, 16'($urandom), 1'($urandom), 1'($urandom),
               2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
               3'($urandom), 2'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule